// File: doc/BRIEF.md
# Serial EEPROM Page-Write Sequencer

This block sits between a client and a byte-level two-wire bus master. It turns one request into the bus transactions a serial EEPROM expects. A request carries a direction, a 7-bit device address, a start offset, a length and an offset width of one or two bytes. Writes are cut into segments that never cross an 8-byte page. The segment that starts at an unaligned offset is sent first, and it stops at the next page boundary. After every STOP the block waits out the device's internal write cycle before it sends the next START.

Reads are random-address reads. The block first sends a dummy write that loads the offset. It then sends a repeated START with the read address and receives the bytes one at a time.

Write data arrives on a valid/ready stream, and read data leaves on one. The block stalls on either stream and never drops a byte. The master is driven through a one-command-at-a-time port, and each command is answered by a single response beat. When the request finishes, the block pulses done, together with an error flag and the number of bytes transferred.

Top module: `eeprom_page_seq`

## Requirements
- R1: Each write segment is issued on the command port, encoded as START=0, WRITE=1, READ=2, STOP=3, in this order: START, WRITE of the address byte {dev,0}, the offset bytes, the segment's data bytes, then STOP. Each command is held stable while `cmd_ready_i` is low, and the next command is not issued before the response beat of the current one.
- R2: No write segment crosses an 8-byte page boundary. The first segment starts at the request offset and ends at the next multiple of 8 or at the end of the request. Each later segment starts on a multiple of 8 and carries at most 8 bytes.
- R3: With `req_wide_i`=1 the offset is sent as two WRITE bytes, high byte first and low byte second. With `req_wide_i`=0 only the low byte is sent.
- R4: After the response to a segment's STOP, the next START is issued exactly HEAD_MS*CLK_PER_MS cycles later if that segment began at an unaligned offset. Otherwise the wait is PAGE_MS*CLK_PER_MS cycles. The wait also follows the last segment, before done.
- R5: A read issues START, WRITE {dev,0}, the offset bytes, START, WRITE {dev,1}, then one READ per byte, then STOP. The no-acknowledge flag `cmd_nak_o` is set on the final READ only. Received bytes appear on the read stream in order.
- R6: A request that completes normally gives a one-cycle `done_o` with `err_o`=0 and `count_o` equal to the length.
- R7: A response with `rsp_ok_i`=0 to START or to any WRITE (address, offset or data) is followed by STOP only. The request then ends with `err_o`=1, and `count_o` holds the data bytes acknowledged before the failure.
- R8: A request accepted while `arb_lost_i` is high issues no command. It pulses `arb_clr_o` in the accept cycle and ends with `err_o`=1 and `count_o`=0 one cycle later.
- R9: With `wr_valid_i` low no data WRITE is issued. With `rd_ready_i` low, `rd_valid_o` and `rd_data_o` hold. No byte is lost or repeated.
- R10: A request of length zero issues no command and ends with `err_o`=0 and `count_o`=0.
- R11: In reset the block is idle: `req_ready_o`=1, while `cmd_valid_o`, `done_o` and `rd_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_wide_i | input | 1 | Two-byte offset |
| req_dev_i | input | 7 | Device address |
| req_off_i | input | 16 | Start offset |
| req_len_i | input | LEN_W | Byte count |
| wr_data_i | input | 8 | Write stream data |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |
| rd_data_o | output | 8 | Read stream data |
| rd_valid_o | output | 1 | Read stream valid |
| rd_ready_i | input | 1 | Read stream ready |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Master takes command |
| cmd_op_o | output | 2 | Command code |
| cmd_byte_o | output | 8 | Byte to send |
| cmd_nak_o | output | 1 | Answer the received byte with NAK |
| rsp_valid_i | input | 1 | Command finished |
| rsp_ok_i | input | 1 | START won or byte acknowledged |
| rsp_data_i | input | 8 | Received byte |
| arb_lost_i | input | 1 | Arbitration-lost flag pending |
| arb_clr_o | output | 1 | Clear the arbitration-lost flag |
| done_o | output | 1 | Request finished (one cycle) |
| err_o | output | 1 | Request failed, valid with done |
| count_o | output | LEN_W | Bytes transferred, valid with done |

## Verification
A wrong segment counter or offset shows up at the command port within the same segment, as a STOP too early or too late, or as an offset byte with the wrong value. The bench compares every command against a list it builds itself. A timer loaded with the wrong delay moves the next START by a measurable number of cycles, which is checked exactly for every page gap. Broken stream handshakes show up as missing, repeated or reordered data bytes in the command log or on the read stream. A broken abort path shows up within a few cycles as extra commands or a wrong result count.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR_W, S_OFF_HI, S_OFF_LO, S_DATA,
    S_ADDR_R, S_READ, S_PUSH, S_STOP, S_WAIT, S_DONE
  } st_e;
endpackage

// File: rtl/eeprom_seg_calc.sv
module eeprom_seg_calc #(
  parameter int unsigned PAGE  = 8,
  parameter int unsigned LEN_W = 8
) (
  input  logic [15:0]      off_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [LEN_W-1:0] seg_o,
  output logic             unaligned_o
);
  localparam int unsigned PB = $clog2(PAGE);

  logic [31:0] room;

  always_comb begin
    room        = 32'(PAGE) - 32'(off_i[PB-1:0]);
    seg_o       = (32'(rem_i) < room) ? rem_i : LEN_W'(room);
    unaligned_o = (off_i[PB-1:0] != '0);
  end
endmodule

// File: rtl/eeprom_wait_timer.sv
module eeprom_wait_timer #(
  parameter int unsigned CLK_PER_MS = 100000,
  parameter int unsigned HEAD_MS    = 32,
  parameter int unsigned PAGE_MS    = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic head_i,
  output logic expired_o
);
  localparam int unsigned HEAD_CYC = HEAD_MS * CLK_PER_MS;
  localparam int unsigned PAGE_CYC = PAGE_MS * CLK_PER_MS;
  localparam int unsigned MAX_CYC  = (HEAD_CYC > PAGE_CYC) ? HEAD_CYC : PAGE_CYC;
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= head_i ? CW'(HEAD_CYC) : CW'(PAGE_CYC);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign expired_o = (cnt_q == CW'(1));
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq
  import eeprom_seq_pkg::*;
#(
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned PAGE       = 8,
  parameter int unsigned CLK_PER_MS = 100000,
  parameter int unsigned HEAD_MS    = 32,
  parameter int unsigned PAGE_MS    = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_read_i,
  input  logic             req_wide_i,
  input  logic [6:0]       req_dev_i,
  input  logic [15:0]      req_off_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [1:0]       cmd_op_o,
  output logic [7:0]       cmd_byte_o,
  output logic             cmd_nak_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_ok_i,
  input  logic [7:0]       rsp_data_i,
  input  logic             arb_lost_i,
  output logic             arb_clr_o,
  output logic             done_o,
  output logic             err_o,
  output logic [LEN_W-1:0] count_o
);
  localparam int unsigned PB = $clog2(PAGE);

  st_e              state_q;
  logic             pend_q, read_q, wide_q, err_q, rep_q, have_q, head_q;
  logic [6:0]       dev_q;
  logic [15:0]      off_q;
  logic [LEN_W-1:0] rem_q, seg_q, cnt_q;
  logic [7:0]       wbyte_q, rbyte_q;

  logic [LEN_W-1:0] seg_len;
  logic             seg_unal, tmr_exp, tmr_load, got, fire;
  op_e              op;

  eeprom_seg_calc #(.PAGE(PAGE), .LEN_W(LEN_W)) u_seg (
    .off_i(off_q), .rem_i(rem_q), .seg_o(seg_len), .unaligned_o(seg_unal)
  );

  eeprom_wait_timer #(.CLK_PER_MS(CLK_PER_MS), .HEAD_MS(HEAD_MS), .PAGE_MS(PAGE_MS)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .head_i(head_q), .expired_o(tmr_exp)
  );

  assign req_ready_o = (state_q == S_IDLE);
  assign arb_clr_o   = req_ready_o & req_valid_i & arb_lost_i;
  assign wr_ready_o  = (state_q == S_DATA) & ~have_q & ~pend_q;
  assign rd_valid_o  = (state_q == S_PUSH);
  assign rd_data_o   = rbyte_q;
  assign done_o      = (state_q == S_DONE);
  assign err_o       = err_q;
  assign count_o     = cnt_q;

  always_comb begin
    cmd_valid_o = 1'b0;
    op          = OP_WRITE;
    cmd_byte_o  = 8'h00;
    cmd_nak_o   = 1'b0;
    unique case (state_q)
      S_START:  begin cmd_valid_o = ~pend_q; op = OP_START; end
      S_ADDR_W: begin cmd_valid_o = ~pend_q; cmd_byte_o = {dev_q, 1'b0}; end
      S_ADDR_R: begin cmd_valid_o = ~pend_q; cmd_byte_o = {dev_q, 1'b1}; end
      S_OFF_HI: begin cmd_valid_o = ~pend_q; cmd_byte_o = off_q[15:8]; end
      S_OFF_LO: begin cmd_valid_o = ~pend_q; cmd_byte_o = off_q[7:0]; end
      S_DATA:   begin cmd_valid_o = have_q & ~pend_q; cmd_byte_o = wbyte_q; end
      S_READ:   begin cmd_valid_o = ~pend_q; op = OP_READ; cmd_nak_o = (rem_q == LEN_W'(1)); end
      S_STOP:   begin cmd_valid_o = ~pend_q; op = OP_STOP; end
      default:  ;
    endcase
  end
  assign cmd_op_o = op;

  assign fire     = cmd_valid_o & cmd_ready_i;
  assign got      = pend_q & rsp_valid_i;
  assign tmr_load = (state_q == S_STOP) & got & ~err_q & ~read_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pend_q  <= 1'b0;
      read_q  <= 1'b0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      rep_q   <= 1'b0;
      have_q  <= 1'b0;
      head_q  <= 1'b0;
      dev_q   <= '0;
      off_q   <= '0;
      rem_q   <= '0;
      seg_q   <= '0;
      cnt_q   <= '0;
      wbyte_q <= '0;
      rbyte_q <= '0;
    end else begin
      if (fire) pend_q <= 1'b1;
      if (got)  pend_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          read_q <= req_read_i;
          wide_q <= req_wide_i;
          dev_q  <= req_dev_i;
          off_q  <= req_off_i;
          rem_q  <= req_len_i;
          cnt_q  <= '0;
          err_q  <= arb_lost_i;
          rep_q  <= 1'b0;
          have_q <= 1'b0;
          if (arb_lost_i || req_len_i == '0) state_q <= S_DONE;
          else                               state_q <= S_START;
        end
        S_START: if (got) begin
          if (!rsp_ok_i) begin err_q <= 1'b1; state_q <= S_STOP; end
          else if (rep_q) state_q <= S_ADDR_R;
          else begin
            seg_q   <= seg_len;
            head_q  <= seg_unal;
            state_q <= S_ADDR_W;
          end
        end
        S_ADDR_W: if (got) begin
          if (!rsp_ok_i) begin err_q <= 1'b1; state_q <= S_STOP; end
          else state_q <= wide_q ? S_OFF_HI : S_OFF_LO;
        end
        S_OFF_HI: if (got) begin
          if (!rsp_ok_i) begin err_q <= 1'b1; state_q <= S_STOP; end
          else state_q <= S_OFF_LO;
        end
        S_OFF_LO: if (got) begin
          if (!rsp_ok_i) begin err_q <= 1'b1; state_q <= S_STOP; end
          else if (read_q) begin rep_q <= 1'b1; state_q <= S_START; end
          else state_q <= S_DATA;
        end
        S_DATA: begin
          if (wr_ready_o && wr_valid_i) begin wbyte_q <= wr_data_i; have_q <= 1'b1; end
          if (fire) have_q <= 1'b0;
          if (got) begin
            if (!rsp_ok_i) begin err_q <= 1'b1; state_q <= S_STOP; end
            else begin
              cnt_q <= cnt_q + LEN_W'(1);
              rem_q <= rem_q - LEN_W'(1);
              seg_q <= seg_q - LEN_W'(1);
              off_q <= off_q + 16'd1;
              if (seg_q == LEN_W'(1)) state_q <= S_STOP;
            end
          end
        end
        S_ADDR_R: if (got) begin
          if (!rsp_ok_i) begin err_q <= 1'b1; state_q <= S_STOP; end
          else state_q <= S_READ;
        end
        S_READ: if (got) begin
          rbyte_q <= rsp_data_i;
          state_q <= S_PUSH;
        end
        S_PUSH: if (rd_ready_i) begin
          cnt_q   <= cnt_q + LEN_W'(1);
          rem_q   <= rem_q - LEN_W'(1);
          state_q <= (rem_q == LEN_W'(1)) ? S_STOP : S_READ;
        end
        S_STOP: if (got) state_q <= (err_q || read_q) ? S_DONE : S_WAIT;
        S_WAIT: if (tmr_exp) state_q <= (rem_q == '0) ? S_DONE : S_START;
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // a data byte accepted inside a segment never sits on the last page slot unless it ends the segment
  assert_data_in_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && got && rsp_ok_i && seg_q != LEN_W'(1)) |-> (off_q[PB-1:0] != PB'(PAGE - 1)));

  assert_wait_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !tmr_exp) |=> (state_q == S_WAIT));

  assert_cmd_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_byte_o) && $stable(cmd_op_o)));

  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  assert_refuse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && arb_lost_i) |=> (done_o && err_o && count_o == '0));
endmodule

// File: tb/eeprom_page_seq_bench.sv
`timescale 1ns/1ps
module eeprom_page_seq_bench;
  localparam int CPM = 4, HMS = 32, PMS = 50;
  localparam int HEAD_N = HMS * CPM;
  localparam int PAGE_N = PMS * CPM;
  localparam int C_START = 0, C_WRITE = 1, C_READ = 2, C_STOP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid, req_ready, req_read, req_wide;
  logic [6:0] req_dev;
  logic [15:0] req_off;
  logic [7:0] req_len;
  logic [7:0] wr_data; logic wr_valid, wr_ready;
  logic [7:0] rd_data; logic rd_valid, rd_ready;
  logic cmd_valid, cmd_ready, cmd_nak;
  logic [1:0] cmd_op; logic [7:0] cmd_byte;
  logic rsp_valid, rsp_ok; logic [7:0] rsp_data;
  logic arb_lost, arb_clr, done, err;
  logic [7:0] count;

  eeprom_page_seq #(.LEN_W(8), .PAGE(8), .CLK_PER_MS(CPM), .HEAD_MS(HMS), .PAGE_MS(PMS)) u_eeprom_page_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_read_i(req_read), .req_wide_i(req_wide),
    .req_dev_i(req_dev), .req_off_i(req_off), .req_len_i(req_len),
    .wr_data_i(wr_data), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op), .cmd_byte_o(cmd_byte), .cmd_nak_o(cmd_nak),
    .rsp_valid_i(rsp_valid), .rsp_ok_i(rsp_ok), .rsp_data_i(rsp_data),
    .arb_lost_i(arb_lost), .arb_clr_o(arb_clr),
    .done_o(done), .err_o(err), .count_o(count)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int log_op[256], log_byte[256], log_nak[256], log_cyc[256], rsp_cyc[256];
  int log_n, nak_idx, rd_n, wr_idx, wlen, rd_got;
  int rs_busy, rs_wait, rs_idx, rdy_snap;
  logic [15:0] rd_base;
  logic [7:0] wdat[256], rd_buf[256];
  int e_op[256], e_byte[256], e_nak[256], e_gap[256];
  int e_n;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [15:0] t;
    t = a * 16'd13 + 16'd5;
    return t[7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bus master model and stream agents, all driven at the falling edge
  initial begin
    req_valid = 0; req_read = 0; req_wide = 0; req_dev = 0; req_off = 0; req_len = 0;
    wr_data = 0; wr_valid = 0; rd_ready = 0; cmd_ready = 0; rsp_valid = 0; rsp_ok = 0;
    rsp_data = 0; arb_lost = 0;
    log_n = 0; nak_idx = -1; rd_n = 0; wr_idx = 0; wlen = 0; rd_got = 0;
    rs_busy = 0; rs_wait = 0; rs_idx = 0; rdy_snap = 0; rd_base = 0;
    forever begin
      @(negedge clk);
      if (wr_valid && rdy_snap != 0) wr_idx++;
      rdy_snap = int'(wr_ready);
      if (wr_idx < wlen && ($urandom % 4) != 0) begin
        wr_valid = 1; wr_data = wdat[wr_idx];
      end else wr_valid = 0;
      rd_ready = 0;
      if (rd_valid && ($urandom % 3) != 0) begin
        rd_buf[rd_got] = rd_data; rd_got++; rd_ready = 1;
      end
      cmd_ready = 0; rsp_valid = 0;
      if (rs_busy != 0) begin
        if (rs_wait == 0) begin
          rsp_ok   = (rs_idx != nak_idx);
          rsp_data = mem_byte(rd_base + 16'(rd_n));
          if (log_op[rs_idx] == C_READ) rd_n++;
          rsp_valid = 1;
          rsp_cyc[rs_idx] = cyc;
          rs_busy = 0;
        end else rs_wait--;
      end else if (cmd_valid) begin
        log_op[log_n] = int'(cmd_op); log_byte[log_n] = int'(cmd_byte);
        log_nak[log_n] = int'(cmd_nak); log_cyc[log_n] = cyc;
        rs_idx = log_n; log_n++;
        cmd_ready = 1; rs_busy = 1; rs_wait = int'($urandom % 3);
      end
    end
  end

  task automatic push(input int o, input int b, input int n);
    e_op[e_n] = o; e_byte[e_n] = b; e_nak[e_n] = n; e_gap[e_n] = 0; e_n++;
  endtask

  task automatic run(input bit rd, input bit wide, input logic [6:0] dev, input logic [15:0] off,
                     input int len, input int nak_at, input bit arb, input string tag);
    int t, exp_cnt, exp_err, rem, n, k, fd, bad, first_bad;
    logic [15:0] o;
    bit clr_seen, g_err;
    int g_cnt;
    @(negedge clk); #1;
    log_n = 0; rd_n = 0; rd_got = 0; rd_base = off; nak_idx = nak_at;
    for (int i = 0; i < 256; i++) wdat[i] = 8'($urandom);
    wr_idx = 0; wlen = rd ? 0 : len;
    req_valid = 1; req_read = rd; req_wide = wide; req_dev = dev; req_off = off;
    req_len = 8'(len); arb_lost = arb;
    #1 clr_seen = arb_clr;
    @(negedge clk); #1;
    req_valid = 0; arb_lost = 0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); #1; t++; end
    g_err = err; g_cnt = int'(count);
    chk(done, {tag, " R6 done reached"}, int'(done), 1);
    wlen = 0;
    // expected command list
    e_n = 0; exp_err = 0; exp_cnt = len;
    fd = wide ? 4 : 3;
    if (arb) begin exp_err = 1; exp_cnt = 0; end
    else if (len > 0 && !rd) begin
      rem = len; o = off; k = 0;
      while (rem > 0) begin
        n = 8 - int'(o % 16'd8);
        if (rem < n) n = rem;
        push(C_START, 0, 0); push(C_WRITE, {dev, 1'b0}, 0);
        if (wide) push(C_WRITE, int'(o[15:8]), 0);
        push(C_WRITE, int'(o[7:0]), 0);
        for (int j = 0; j < n; j++) begin push(C_WRITE, int'(wdat[k]), 0); k++; end
        push(C_STOP, 0, 0);
        if (rem - n > 0) e_gap[e_n-1] = ((o % 16'd8) != 0) ? HEAD_N + 1 : PAGE_N + 1;
        o = o + 16'(n); rem = rem - n;
      end
    end else if (len > 0) begin
      push(C_START, 0, 0); push(C_WRITE, {dev, 1'b0}, 0);
      if (wide) push(C_WRITE, int'(off[15:8]), 0);
      push(C_WRITE, int'(off[7:0]), 0);
      push(C_START, 0, 0); push(C_WRITE, {dev, 1'b1}, 0);
      for (int j = 0; j < len; j++) push(C_READ, 0, (j == len - 1) ? 1 : 0);
      push(C_STOP, 0, 0);
    end
    if (nak_at >= 0) begin
      e_n = nak_at + 1; push(C_STOP, 0, 0); exp_err = 1;
      exp_cnt = (!rd && nak_at >= fd) ? nak_at - fd : 0;
      for (int i = 0; i < e_n; i++) e_gap[i] = 0;
    end
    bad = 0; first_bad = -1;
    for (int i = 0; i < e_n && i < log_n; i++)
      if (log_op[i] != e_op[i] || log_byte[i] != e_byte[i] || log_nak[i] != e_nak[i]) begin
        bad++; if (first_bad < 0) first_bad = i;
      end
    chk(log_n == e_n && bad == 0, {tag, " R1/R3 command stream (entries)"}, log_n, e_n);
    if (first_bad >= 0)
      $display("  entry %0d: op %0d byte %0h nak %0d, expected op %0d byte %0h nak %0d", first_bad,
               log_op[first_bad], log_byte[first_bad], log_nak[first_bad],
               e_op[first_bad], e_byte[first_bad], e_nak[first_bad]);
    for (int i = 0; i + 1 < e_n && i + 1 < log_n; i++)
      if (e_gap[i] != 0)
        chk(log_cyc[i+1] - rsp_cyc[i] == e_gap[i], {tag, " R4 page wait"}, log_cyc[i+1] - rsp_cyc[i], e_gap[i]);
    chk(g_err == exp_err[0], {tag, " R6/R7 error flag"}, int'(g_err), exp_err);
    chk(g_cnt == exp_cnt, {tag, " R6/R7 count"}, g_cnt, exp_cnt);
    if (arb) chk(clr_seen, {tag, " R8 flag clear pulse"}, int'(clr_seen), 1);
    if (rd && nak_at < 0 && !arb) begin
      bad = 0;
      for (int i = 0; i < len; i++) if (rd_buf[i] != mem_byte(off + 16'(i))) bad++;
      chk(rd_got == len && bad == 0, {tag, " R5/R9 read stream bytes"}, rd_got, len);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(req_ready && !cmd_valid && !done && !rd_valid, "R11 reset state", int'(req_ready), 1);
    rst_n = 1;
    run(0, 0, 7'h50, 16'h0000, 8, -1, 0, "R1 aligned write");
    run(0, 0, 7'h50, 16'h0005, 14, -1, 0, "R2 unaligned head");
    run(0, 1, 7'h51, 16'h0123, 20, -1, 0, "R3 wide write");
    run(0, 0, 7'h52, 16'h0003, 3, -1, 0, "R2 inside one page");
    run(0, 0, 7'h52, 16'h0006, 4, -1, 0, "R2 short crossing");
    run(1, 0, 7'h53, 16'h0010, 1, -1, 0, "R5 single read");
    run(1, 1, 7'h53, 16'h01FE, 5, -1, 0, "R5 wide read");
    run(0, 0, 7'h54, 16'h0000, 4, 1, 0, "R7 address nak");
    run(1, 1, 7'h54, 16'h0020, 3, 3, 0, "R7 offset nak");
    run(0, 0, 7'h54, 16'h0000, 6, 5, 0, "R7 data nak");
    run(0, 0, 7'h55, 16'h0000, 4, -1, 1, "R8 arbitration refuse");
    run(0, 0, 7'h55, 16'h0008, 0, -1, 0, "R10 zero write");
    run(1, 0, 7'h55, 16'h0008, 0, -1, 0, "R10 zero read");
    for (int r = 0; r < 8; r++)
      run(1'($urandom), 1'($urandom), 7'($urandom), 16'($urandom % 512), 1 + int'($urandom % 18),
          -1, 0, "R9 random mix");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule